// File: doc/BRIEF.md
# Masked Level Interrupt Pending Logic

This block collects interrupt requests from eight processor interrupt lines into the pending field of a 32-bit cause register. It checks them against a 32-bit software-loaded status register and drives one interrupt request to the processor. Requests arrive as single-line update events. Each event carries a line index, a flag that picks the external-device numbering, and a level. A high level marks the line pending. A low level clears it again, so the pending field tracks the most recent level on each line rather than latching it. External device inputs sit two lines above the processor numbering, so device input k lands on processor line k+2.

The processor request is the global enable bit of the status register ANDed with "any pending line whose mask bit is set". It is computed combinationally from the two registers. A status write can therefore raise or drop the request with no new request event. Each line also has a saturating counter. It counts the request events that were actually forwarded, meaning the line was driven high while it was both globally enabled and unmasked. A select port reads the counters one at a time. The pending and mask fields are also brought out as 8-bit diagnostic vectors.

Top module: `irqp_ctrl`

## Requirements
- R1: After a synchronous reset, the cause register, the status register, the processor request, the diagnostic vectors and every forwarding counter are zero.
- R2: An event with `ev_ext`=0, a valid index n (0 to 7) and level L sets cause bit 8+n to L in the cycle after the event. No other cause bit changes.
- R3: An event whose target line is 8 or more changes neither the cause register nor any counter. With `ev_ext`=0 that is an index of 8 or more; with `ev_ext`=1 it is an index of 6 or more.
- R4: An event with `ev_ext`=1 and index k acts on processor line k+2, so cause bit 10+k follows its level.
- R5: A status write loads all 32 bits of `stat_wdata` into the status register, visible in the next cycle. Without a write, the status register holds its value.
- R6: `cpu_irq` is 1 exactly when status bit 0 is 1 and some n has both cause bit 8+n and status bit 8+n set. It follows the register values in the same cycle, with no added delay.
- R7: `diag_pend` equals cause bits 15:8 and `diag_mask` equals status bits 15:8 (bit n of each vector belongs to line n).
- R8: The counter for line n increments by one for each high-level event on line n for which the status register, as it stood before that edge, has bit 0 and bit 8+n set. This holds even when the line is already pending. Events that are low, masked or globally disabled leave the counter unchanged, and so does a status write in the same cycle.
- R9: A counter stops at 2^CNT_W-1 and does not wrap.
- R10: `cnt_val` presents the counter of line `cnt_sel` one cycle after `cnt_sel` is applied.
- R11: Cause bits outside 15:8 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Request update event strobe |
| ev_ext | input | 1 | 1: index uses external device numbering (line = index+2) |
| ev_idx | input | IDX_W | Line index of the event |
| ev_level | input | 1 | New level of the addressed line |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | REG_W | Status register write value |
| cnt_sel | input | SEL_W | Forwarding counter select |
| cause_val | output | REG_W | Cause register (pending field in bits 15:8) |
| status_val | output | REG_W | Status register |
| cpu_irq | output | 1 | Interrupt request to the processor |
| diag_pend | output | NUM_LINES | Pending vector, one bit per line |
| diag_mask | output | NUM_LINES | Mask vector, one bit per line |
| cnt_val | output | CNT_W | Selected forwarding counter |

## Verification
The bench keeps the default eight lines, the 4-bit index and the offset of two. With a 4-bit index, every direct and external index from 0 to 15 can be swept, which covers all the out-of-range targets. The counter width is reduced to 3 bits, so saturation at 7 is reached within ten events. With one line pending at a time, the request output is checked against every 8-bit mask pattern with the global enable both off and on.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

  // Numbering in which an update event names its line
  typedef enum logic {
    SRC_CPU = 1'b0,
    SRC_EXT = 1'b1
  } irq_src_e;

endpackage

// File: rtl/irqp_line_decode.sv
// Turns one update event into a one-hot hit vector over processor lines.
module irqp_line_decode
  import irqp_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter int IDX_W      = 4,
  parameter int EXT_OFFSET = 2
) (
  input  logic                 ev_valid,
  input  irq_src_e             ev_src,
  input  logic [IDX_W-1:0]     ev_idx,
  output logic [NUM_LINES-1:0] hit
);
  localparam int TGT_W = IDX_W + 1;

  logic [TGT_W-1:0] tgt;

  // one extra bit keeps idx+offset from wrapping back into range
  assign tgt = {1'b0, ev_idx} + ((ev_src == SRC_EXT) ? TGT_W'(EXT_OFFSET) : '0);

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_hit
    assign hit[n] = ev_valid && (tgt == TGT_W'(n));
  end
endmodule

// File: rtl/irqp_pend_bank.sv
// One pending flop per line, following the level of the last event on it.
module irqp_pend_bank #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] hit,
  input  logic                 level,
  output logic [NUM_LINES-1:0] pend
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         pend[n] <= 1'b0;
      else if (hit[n]) pend[n] <= level;
    end
  end
endmodule

// File: rtl/irqp_fwd_count.sv
// Saturating per-line counters of forwarded requests, with a registered read port.
module irqp_fwd_count #(
  parameter int NUM_LINES = 8,
  parameter int CNT_W     = 16,
  parameter int SEL_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] fwd,
  input  logic [SEL_W-1:0]     rd_sel,
  output logic [CNT_W-1:0]     rd_val
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt [NUM_LINES];

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)                              cnt[n] <= '0;
      else if (fwd[n] && cnt[n] != CNT_MAX) cnt[n] <= cnt[n] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          rd_val <= '0;
    else if (32'(rd_sel) < NUM_LINES) rd_val <= cnt[rd_sel];
    else                              rd_val <= '0;
  end
endmodule

// File: rtl/irqp_ctrl.sv
module irqp_ctrl
  import irqp_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter int REG_W      = 32,
  parameter int LINE_BASE  = 8,
  parameter int EXT_OFFSET = 2,
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 16,
  parameter int SEL_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_valid,
  input  logic                 ev_ext,
  input  logic [IDX_W-1:0]     ev_idx,
  input  logic                 ev_level,
  input  logic                 stat_we,
  input  logic [REG_W-1:0]     stat_wdata,
  input  logic [SEL_W-1:0]     cnt_sel,
  output logic [REG_W-1:0]     cause_val,
  output logic [REG_W-1:0]     status_val,
  output logic                 cpu_irq,
  output logic [NUM_LINES-1:0] diag_pend,
  output logic [NUM_LINES-1:0] diag_mask,
  output logic [CNT_W-1:0]     cnt_val
);
  localparam int GEN_BIT = 0;

  irq_src_e             src;
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] fwd;
  logic [REG_W-1:0]     status_q;

  assign src = irq_src_e'(ev_ext);

  irqp_line_decode #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W),
    .EXT_OFFSET(EXT_OFFSET)
  ) u_dec (
    .ev_valid(ev_valid),
    .ev_src  (src),
    .ev_idx  (ev_idx),
    .hit     (hit)
  );

  irqp_pend_bank #(
    .NUM_LINES(NUM_LINES)
  ) u_pend (
    .clk  (clk),
    .rst  (rst),
    .hit  (hit),
    .level(ev_level),
    .pend (pend)
  );

  always_ff @(posedge clk) begin
    if (rst)          status_q <= '0;
    else if (stat_we) status_q <= stat_wdata;
  end

  // forwarding uses the status value held before this edge
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_fwd
    assign fwd[n] = hit[n] & ev_level & status_q[GEN_BIT] & status_q[LINE_BASE+n];
  end

  irqp_fwd_count #(
    .NUM_LINES(NUM_LINES),
    .CNT_W    (CNT_W),
    .SEL_W    (SEL_W)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .fwd   (fwd),
    .rd_sel(cnt_sel),
    .rd_val(cnt_val)
  );

  always_comb begin
    cause_val = '0;
    cause_val[LINE_BASE +: NUM_LINES] = pend;
  end

  assign status_val = status_q;
  assign diag_pend  = pend;
  assign diag_mask  = status_q[LINE_BASE +: NUM_LINES];
  assign cpu_irq    = status_q[GEN_BIT] & (|(pend & status_q[LINE_BASE +: NUM_LINES]));
endmodule

// File: rtl/irqp_ctrl_chk.sv
module irqp_ctrl_chk #(
  parameter int NUM_LINES  = 8,
  parameter int REG_W      = 32,
  parameter int LINE_BASE  = 8,
  parameter int EXT_OFFSET = 2,
  parameter int IDX_W      = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ev_valid,
  input logic                 ev_ext,
  input logic [IDX_W-1:0]     ev_idx,
  input logic                 ev_level,
  input logic                 stat_we,
  input logic [REG_W-1:0]     stat_wdata,
  input logic [REG_W-1:0]     cause_val,
  input logic [REG_W-1:0]     status_val,
  input logic                 cpu_irq,
  input logic [NUM_LINES-1:0] diag_pend,
  input logic [NUM_LINES-1:0] diag_mask
);
  localparam int TGT_W = IDX_W + 1;

  logic [TGT_W-1:0] tgt;
  logic [REG_W-1:0] outside;

  assign tgt     = {1'b0, ev_idx} + (ev_ext ? TGT_W'(EXT_OFFSET) : '0);
  assign outside = cause_val & ~({{(REG_W-NUM_LINES){1'b0}}, {NUM_LINES{1'b1}}} << LINE_BASE);

  AST_CAUSE_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (rst) outside == '0); // R11
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst) cpu_irq |-> status_val[0]); // R6
  AST_IRQ_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst) cpu_irq |-> |(diag_pend & diag_mask)); // R6
  AST_IRQ_WHEN_MATCH: assert property (@(posedge clk) disable iff (rst) (status_val[0] && |(diag_pend & diag_mask)) |-> cpu_irq); // R6
  AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (rst) stat_we |=> status_val == $past(stat_wdata)); // R5
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst) !stat_we |=> $stable(status_val)); // R5
  AST_DIAG_PEND: assert property (@(posedge clk) disable iff (rst) diag_pend == cause_val[LINE_BASE +: NUM_LINES]); // R7
  AST_BADIDX_STABLE: assert property (@(posedge clk) disable iff (rst) (ev_valid && 32'(tgt) >= NUM_LINES) |=> $stable(cause_val)); // R3
  AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (ev_valid && 32'(tgt) < NUM_LINES) |=> cause_val[LINE_BASE + 32'($past(tgt))] == $past(ev_level)); // R2
endmodule

bind irqp_ctrl irqp_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .REG_W     (REG_W),
  .LINE_BASE (LINE_BASE),
  .EXT_OFFSET(EXT_OFFSET),
  .IDX_W     (IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ev_valid  (ev_valid),
  .ev_ext    (ev_ext),
  .ev_idx    (ev_idx),
  .ev_level  (ev_level),
  .stat_we   (stat_we),
  .stat_wdata(stat_wdata),
  .cause_val (cause_val),
  .status_val(status_val),
  .cpu_irq   (cpu_irq),
  .diag_pend (diag_pend),
  .diag_mask (diag_mask)
);

// File: tb/tb_irqp_ctrl.sv
module tb_irqp_ctrl;
  localparam int NL = 8, RW = 32, LB = 8, EO = 2, IW = 4, CW = 3, SW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, ev_valid, ev_ext, ev_level, stat_we, cpu_irq;
  logic [IW-1:0] ev_idx;
  logic [RW-1:0] stat_wdata, cause_val, status_val;
  logic [SW-1:0] cnt_sel;
  logic [NL-1:0] diag_pend, diag_mask;
  logic [CW-1:0] cnt_val;

  irqp_ctrl #(.NUM_LINES(NL), .REG_W(RW), .LINE_BASE(LB), .EXT_OFFSET(EO),
              .IDX_W(IW), .CNT_W(CW), .SEL_W(SW)) dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [NL-1:0] e_pend = '0;
  logic [RW-1:0] e_stat = '0;
  int e_cnt[NL];

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic model_event(bit ext, int idx, bit lvl);
    int tgt = idx + (ext ? EO : 0);
    if (tgt < NL) begin
      if (lvl && e_stat[0] && e_stat[LB+tgt] && e_cnt[tgt] < CMAX) e_cnt[tgt]++;
      e_pend[tgt] = lvl;
    end
  endtask

  task automatic send(bit ext, int idx, bit lvl);
    model_event(ext, idx, lvl);
    ev_valid = 1'b1; ev_ext = ext; ev_idx = IW'(idx); ev_level = lvl;
    tick();
    ev_valid = 1'b0;
  endtask

  task automatic stat_wr(logic [RW-1:0] v);
    stat_we = 1'b1; stat_wdata = v;
    tick();
    stat_we = 1'b0;
    e_stat = v;
  endtask

  task automatic check_regs(string rq);
    chk(rq, cause_val, {16'h0, e_pend, 8'h0});
    chk("R5 status", status_val, e_stat);
    chk("R6 cpu_irq", {31'h0, cpu_irq}, {31'h0, e_stat[0] & (|(e_pend & e_stat[15:8]))});
    chk("R7 diag", {16'h0, diag_pend, diag_mask}, {16'h0, e_pend, e_stat[15:8]});
  endtask

  task automatic read_cnts(string rq);
    for (int n = 0; n < NL; n++) begin
      cnt_sel = SW'(n);
      tick();
      chk(rq, {29'h0, cnt_val}, 32'(e_cnt[n]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int n = 0; n < NL; n++) e_cnt[n] = 0;
    rst = 1'b1; ev_valid = 0; ev_ext = 0; ev_idx = '0; ev_level = 0;
    stat_we = 0; stat_wdata = '0; cnt_sel = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check_regs("R1 cause");
    read_cnts("R1 counter");

    // R2: direct lines set and clear one by one
    for (int i = 0; i < NL; i++) begin
      send(0, i, 1); check_regs("R2 set");
      send(0, i, 0); check_regs("R2 clear");
    end
    // R3: out-of-range indexes with all lines pending, then with none
    for (int i = 0; i < NL; i++) send(0, i, 1);
    check_regs("R2 all");
    for (int i = NL; i < 16; i++) begin send(0, i, 0); check_regs("R3 direct"); end
    for (int i = NL - EO; i < 16; i++) begin send(1, i, 0); check_regs("R3 ext"); end
    for (int i = 0; i < NL; i++) send(0, i, 0);
    for (int i = NL; i < 16; i++) begin send(0, i, 1); check_regs("R3 direct hi"); end
    for (int i = NL - EO; i < 16; i++) begin send(1, i, 1); check_regs("R3 ext hi"); end

    // R4: external numbering lands two lines up
    for (int k = 0; k < NL - EO; k++) begin send(1, k, 1); check_regs("R4 set"); end
    for (int k = 0; k < NL - EO; k++) begin send(1, k, 0); check_regs("R4 clear"); end
    read_cnts("R8 none forwarded");

    // R5 R6 R7: every mask with enable off and on, one line pending at a time
    for (int n = 0; n < NL; n++) begin
      send(0, n, 1);
      for (int en = 0; en < 2; en++)
        for (int m = 0; m < 256; m++) begin
          stat_wr({8'(m * 37), 8'(m ^ 8'h5A), 8'(m), 7'(m), 1'(en)});
          check_regs("R6 sweep");
        end
      send(0, n, 0);
      check_regs("R6 drop");
    end
    read_cnts("R8 after sweep");

    // R9: saturation
    stat_wr(32'h0000_FF01);
    for (int r = 0; r < 10; r++) send(0, 3, 1);
    read_cnts("R9 saturate");
    // R8: masked line and disabled global enable do not count
    stat_wr(32'h0000_F701);
    send(0, 3, 1);
    send(0, 1, 1);
    stat_wr(32'h0000_FF00);
    send(0, 4, 1);
    read_cnts("R8 gated");
    // R8: a status write in the same cycle does not affect forwarding
    model_event(0, 5, 1);
    stat_we = 1; stat_wdata = 32'h0000_FF01; ev_valid = 1; ev_ext = 0; ev_idx = 4'd5; ev_level = 1;
    tick();
    e_stat = 32'h0000_FF01;
    model_event(0, 6, 1);
    stat_wdata = 32'h0; ev_idx = 4'd6;
    tick();
    e_stat = 32'h0;
    stat_we = 0; ev_valid = 0;
    check_regs("R8 same cycle");
    read_cnts("R8 same cycle");
    // R10: external event counted on line 2, read through the select port
    stat_wr(32'hFFFF_FFFF);
    send(1, 0, 1);
    send(1, 0, 0);
    send(1, 0, 1);
    check_regs("R4 counted");
    read_cnts("R10 readback");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule